// File: doc/BRIEF.md
# Serial ADC Frame Capture Controller

This block sits on the host side of a three-wire sampling converter link. It makes the serial clock by dividing the system clock by an even factor. It raises a convert strobe once per frame and collects the converter's serial output. Every frame lasts 18 serial clocks. The first 16 clocks carry the data stream. The last two give the converter's input stage time to acquire the next sample. The convert strobe covers the low half of the first serial clock, so it leads the first rising serial edge by half a serial period. This phase relationship is fixed.

The incoming bit is captured on every rising serial clock edge. When the 16th rising edge has been taken, the block cuts a 12-bit or 14-bit field out of the stream and right-aligns it in a 16-bit word. It then marks the word with a one-cycle strobe. In continuous mode the frames follow each other with no gap. In single-shot mode the block sits idle with the serial clock low until a start request arrives. Parameters set the clock divider, the sample width and the stream position of the sample's most significant bit.

Top module: `adc_frame_ctrl`

## Requirements
- R1: After a synchronous reset, `sclk_o`, `conv_o` and `valid_o` are low and `sample_o` is zero.
- R2: While a frame runs, `sclk_o` has a period of `DIV` system clocks. It is low for the first `DIV/2` clocks of each period and high for the rest. A frame contains exactly 18 such periods.
- R3: `conv_o` is high only for the first `DIV/2` system clocks of each frame, while `sclk_o` is low, so it rises half a serial period before the first rising serial edge.
- R4: `sdo_i` is sampled at each of the first 16 rising serial clock edges of a frame. The bit taken at rising edge k (k = 0..15) is stream bit k, and stream bit 0 comes first.
- R5: The result holds stream bits `MSB_POS` to `MSB_POS+SAMPLE_W-1`. Stream bit `MSB_POS` becomes the most significant sample bit. The result sits in bits `SAMPLE_W-1:0` of `sample_o`, and the upper bits are zero.
- R6: `valid_o` is high for exactly one system clock, at `DIV/2` system clocks into serial period 15 of the frame (the clock right after the 16th rising edge). `sample_o` changes only in that cycle and otherwise keeps its last value.
- R7: If `continuous_i` is high when the 18th serial period ends, the next frame's convert strobe starts on the very next system clock.
- R8: With `continuous_i` low, a finished frame leaves the block idle with `sclk_o` and `conv_o` low. From idle, a frame starts on the clock after `start_i` or `continuous_i` is seen high.
- R9: `start_i` has no effect while a frame is running: the frame runs to its end and no extra frame follows it.
- R10: Asserting `rst_i` in the middle of a frame stops it. On the next clock the outputs return to the idle values of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| continuous_i | input | 1 | High selects back-to-back frames |
| start_i | input | 1 | Single-shot frame request, taken only when idle |
| sdo_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| conv_o | output | 1 | Convert strobe to the converter |
| sample_o | output | 16 | Last extracted sample, right-aligned |
| valid_o | output | 1 | One-cycle strobe marking a new sample |

## Verification
The bench goes after the frame joint in continuous mode. A controller that adds an idle clock there would show the convert strobe one clock late, and one that wraps its counter early would shorten the acquisition gap. It also goes after bit ordering and field placement, using all-ones, all-zeros and alternating patterns plus patterns that set only the stream edges. An off-by-one capture edge or a wrong field offset shifts every sample by one bit. Start requests in the middle of a frame and resets in the middle of a frame are issued on purpose. A design that latched the late request would run an extra frame, and one that ignored the reset would keep clocking the converter.

// File: rtl/adc_fc_pkg.sv
package adc_fc_pkg;

    localparam int STREAM_W   = 16;
    localparam int FRAME_CLKS = 18;
    localparam int CNT_W      = 5;

    typedef struct packed {
        logic [STREAM_W-1:0] sh;
        logic [STREAM_W-1:0] data;
        logic                valid;
    } cap_state_t;

endpackage

// File: rtl/adc_fc_seq.sv
module adc_fc_seq
    import adc_fc_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             continuous_i,
    input  logic             start_i,
    output logic             sclk_o,
    output logic             conv_o,
    output logic             rise_o,
    output logic             last_rise_o
);

    localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int HALF = DIV / 2;
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(DIV - 1);
    localparam logic [PH_W-1:0]  PH_HALF  = PH_W'(HALF);
    localparam logic [PH_W-1:0]  PH_PRE   = PH_W'(HALF - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_CLKS - 1);
    localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(STREAM_W);
    localparam logic [CNT_W-1:0] CNT_FIN  = CNT_W'(STREAM_W - 1);

    typedef struct packed {
        logic             active;
        logic [PH_W-1:0]  ph;
        logic [CNT_W-1:0] cnt;
    } seq_state_t;

    seq_state_t s_d, s_q;
    logic       frame_end;

    assign frame_end = s_q.active && (s_q.ph == PH_LAST) && (s_q.cnt == CNT_LAST);

    always_comb begin
        s_d = s_q;
        if (!s_q.active) begin
            if (start_i || continuous_i) begin
                s_d.active = 1'b1;
                s_d.ph     = '0;
                s_d.cnt    = '0;
            end
        end else if (s_q.ph == PH_LAST) begin
            s_d.ph = '0;
            if (s_q.cnt == CNT_LAST) begin
                s_d.cnt    = '0;
                s_d.active = continuous_i;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else begin
            s_d.ph = s_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '0;
        else       s_q <= s_d;
    end

    assign sclk_o      = s_q.active && (s_q.ph >= PH_HALF);
    assign conv_o      = s_q.active && (s_q.cnt == '0) && (s_q.ph < PH_HALF);
    assign rise_o      = s_q.active && (s_q.ph == PH_PRE) && (s_q.cnt < CNT_DATA);
    assign last_rise_o = rise_o && (s_q.cnt == CNT_FIN);

    // R3: strobe only while the serial clock is low
    assert_conv_low_clk_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        conv_o |-> !sclk_o);

    // R9: a running frame is never cut short by request inputs
    assert_frame_holds_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (s_q.active && !frame_end) |=> s_q.active);

    // R7: seamless restart in continuous mode
    assert_back_to_back_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (frame_end && continuous_i) |=> conv_o);

    // R10: reset silences the converter pins on the next cycle
    assert_reset_idle_R10: assert property (@(posedge clk_i)
        rst_i |=> (!sclk_o && !conv_o));

endmodule

// File: rtl/adc_fc_capture.sv
module adc_fc_capture
    import adc_fc_pkg::*;
#(
    parameter int SAMPLE_W = 14,
    parameter int MSB_POS  = 2
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                sdo_i,
    input  logic                rise_i,
    input  logic                last_rise_i,
    output logic [STREAM_W-1:0] data_o,
    output logic                valid_o
);

    localparam int LSB_IDX = STREAM_W - MSB_POS - SAMPLE_W;

    cap_state_t          c_d, c_q;
    logic [STREAM_W-1:0] sh_next;
    logic [SAMPLE_W-1:0] field;
    logic [STREAM_W-1:0] padded;

    always_comb sh_next = {c_q.sh[STREAM_W-2:0], sdo_i};
    always_comb field   = sh_next[LSB_IDX +: SAMPLE_W];

    generate
        if (SAMPLE_W < STREAM_W) begin : g_pad
            assign padded = {{(STREAM_W-SAMPLE_W){1'b0}}, field};
        end else begin : g_full
            assign padded = field;
        end
    endgenerate

    always_comb begin
        c_d       = c_q;
        c_d.valid = 1'b0;
        if (rise_i) begin
            c_d.sh = sh_next;
            if (last_rise_i) begin
                c_d.data  = padded;
                c_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) c_q <= '0;
        else       c_q <= c_d;
    end

    assign data_o  = c_q.data;
    assign valid_o = c_q.valid;

    // R6: the strobe never lasts two cycles
    assert_valid_single_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        c_q.valid |=> !c_q.valid);

    // R6: the result only moves together with the strobe
    assert_hold_result_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (!c_q.valid && !$past(rst_i)) |-> $stable(c_q.data));

    // R4: the shift register only moves on a rising serial edge
    assert_shift_on_rise_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        !rise_i |=> $stable(c_q.sh));

endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
    import adc_fc_pkg::*;
#(
    parameter int DIV      = 4,
    parameter int SAMPLE_W = 14,
    parameter int MSB_POS  = 2
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        continuous_i,
    input  logic        start_i,
    input  logic        sdo_i,
    output logic        sclk_o,
    output logic        conv_o,
    output logic [15:0] sample_o,
    output logic        valid_o
);

    logic rise;
    logic last_rise;

    adc_fc_seq #(
        .DIV (DIV)
    ) u_seq (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .continuous_i (continuous_i),
        .start_i      (start_i),
        .sclk_o       (sclk_o),
        .conv_o       (conv_o),
        .rise_o       (rise),
        .last_rise_o  (last_rise)
    );

    adc_fc_capture #(
        .SAMPLE_W (SAMPLE_W),
        .MSB_POS  (MSB_POS)
    ) u_cap (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .sdo_i       (sdo_i),
        .rise_i      (rise),
        .last_rise_i (last_rise),
        .data_o      (sample_o),
        .valid_o     (valid_o)
    );

    // R5: a fresh sample arrives only in the high half of a serial period
    assert_valid_in_high_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |-> (sclk_o && !conv_o));

endmodule

// File: tb/tb_adc_frame_ctrl.sv
`timescale 1ns/1ps
module tb_adc_frame_ctrl;

    localparam int DIV      = 4;
    localparam int SAMPLE_W = 14;
    localparam int MSB_POS  = 2;
    localparam int HALF     = DIV / 2;
    localparam int FRAME    = 18 * DIV;
    localparam int LSB_IDX  = 16 - MSB_POS - SAMPLE_W;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cont = 1'b0;
    logic        start = 1'b0;
    logic        sdo = 1'b0;
    logic        sclk_o, conv_o, valid_o;
    logic [15:0] sample_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    adc_frame_ctrl #(.DIV(DIV), .SAMPLE_W(SAMPLE_W), .MSB_POS(MSB_POS)) dut (
        .clk_i(clk), .rst_i(rst), .continuous_i(cont), .start_i(start),
        .sdo_i(sdo), .sclk_o(sclk_o), .conv_o(conv_o),
        .sample_o(sample_o), .valid_o(valid_o)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] extract(input logic [15:0] w);
        return 16'((w >> LSB_IDX) & ((1 << SAMPLE_W) - 1));
    endfunction

    // behavioural reference: frame position in system clocks
    bit          mbusy = 0;
    int          mt = 0;
    logic [15:0] exp_hold = '0;
    logic [15:0] exp_q[$];
    logic [15:0] pat_q[$];

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            mbusy = 0; mt = 0; exp_hold = '0; exp_q.delete();
        end else if (!mbusy) begin
            if (start || cont) begin mbusy = 1; mt = 0; end
        end else if (mt == FRAME - 1) begin
            if (cont) mt = 0; else mbusy = 0;
        end else begin
            mt++;
        end
        if (cycles > 150000) begin
            failures++;
            $display("FAIL R8 watchdog actual=%0d expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // converter model and per-cycle comparison, away from the edge
    logic [15:0] word = '0;
    int          k = 16;
    logic        prev_sclk = 1'b0, prev_conv = 1'b0;

    always begin
        @(posedge clk);
        #5;
        if (!rst) begin
            check("R2 R8 sclk", sclk_o, int'(mbusy && ((mt % DIV) >= HALF)));
            check("R3 R7 conv", conv_o, int'(mbusy && (mt < HALF)));
            check("R6 valid",   valid_o, int'(mbusy && (mt == 15 * DIV + HALF)));
            if (valid_o) begin
                if (exp_q.size() == 0) begin
                    checks++; failures++;
                    $display("FAIL R4 R5 unexpected sample actual=%0h expected=none", sample_o);
                end else begin
                    exp_hold = exp_q.pop_front();
                end
            end
            check("R4 R5 R6 sample", sample_o, exp_hold);
        end
        if (conv_o && !prev_conv) begin
            word = (pat_q.size() != 0) ? pat_q.pop_front() : 16'($urandom);
            exp_q.push_back(extract(word));
            k = 0;
        end else if (prev_sclk && !sclk_o && k < 16) begin
            k++;
        end
        sdo = (k < 16) ? word[15 - k] : 1'b0;
        prev_sclk = sclk_o;
        prev_conv = conv_o;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shot(input logic [15:0] w);
        pat_q.push_back(w);
        start = 1'b1; cyc(1); start = 1'b0;
        cyc(FRAME + 4);
        check("R5 single-shot result", sample_o, extract(w));
    endtask

    initial begin
        cyc(3);
        // R1: reset values
        check("R1 sclk", sclk_o, 0); check("R1 conv", conv_o, 0);
        check("R1 valid", valid_o, 0); check("R1 sample", sample_o, 0);
        rst = 1'b0;
        cyc(6);
        check("R8 idle sclk", sclk_o, 0);

        // R4 R5: ordering and field placement
        shot(16'hFFFF);
        shot(16'h0000);
        shot(16'hAAAA);
        shot(16'h5555);
        shot(16'h2001);
        shot(16'hC000);
        shot(16'h8000);

        // R9: start pulses in the middle of a frame
        pat_q.push_back(16'h1234);
        start = 1'b1; cyc(1); start = 1'b0;
        cyc(20); start = 1'b1; cyc(2); start = 1'b0;
        cyc(30); start = 1'b1; cyc(1); start = 1'b0;
        cyc(FRAME);
        check("R9 no extra frame sclk", sclk_o, 0);
        check("R9 no extra frame conv", conv_o, 0);
        check("R9 result", sample_o, extract(16'h1234));

        // R7: back-to-back frames
        pat_q.push_back(16'h3FFF);
        pat_q.push_back(16'h0001);
        cont = 1'b1;
        cyc(6 * FRAME + 3);
        cont = 1'b0;
        cyc(FRAME + 4);
        check("R8 idle after continuous", sclk_o, 0);

        // R10: reset in the middle of a frame
        start = 1'b1; cyc(1); start = 1'b0;
        cyc(25);
        rst = 1'b1; cyc(1);
        check("R10 sclk", sclk_o, 0); check("R10 conv", conv_o, 0);
        check("R10 valid", valid_o, 0); check("R10 sample", sample_o, 0);
        rst = 1'b0;
        cyc(FRAME);
        check("R10 stays idle", sclk_o, 0);

        // R8: continuous from idle starts a frame
        cont = 1'b1; cyc(1); cont = 1'b0;
        cyc(FRAME + 4);
        check("R8 final idle", conv_o, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule